// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block holds the settings that an accelerator's datapath units run with. Software reaches it through a simple memory-mapped slave port. It writes configuration words into a working register file, one byte lane at a time if it wants. The units never see the working file directly. They are fed from a second, shadow copy, and that copy takes a snapshot of the working file only at the moment a run is launched. Software can therefore start a run, return at once, and fill in the settings for the following run while the current one is still executing. The results of the current run are not disturbed.

The bank also sequences the run. A write of one to the control word raises a single-cycle launch pulse towards the units. It holds a busy level high until the units report completion. The completion is recorded in a sticky flag that software polls through the status word. A bank of read-only state words, driven by the units, can be read through the same port. The port accepts reads and writes in every cycle, whether or not a run is in progress.

Top module: `cfg_shadow_bank`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `unit_run`, `unit_running`, `bus_rvalid` and every bit of `unit_cfg` are 0. A status read issued right after reset returns 0.
- R2: A write is an access with `bus_valid` high and a nonzero `bus_wstrb`. A write to configuration word k (word address 2+k) replaces only the byte lanes whose strobe bit is set; strobe bit b covers data bits 8b+7..8b. A later read of that address returns the merged working value.
- R3: Configuration writes never change `unit_cfg` by themselves. This holds for writes made while idle, writes made during the launch cycle and writes made later in a run. `unit_cfg` changes only in a launch cycle.
- R4: A write to the control word (address 0) with strobe bit 0 set and data bit 0 equal to 1, made while idle, raises `unit_run` in the next cycle for exactly one cycle. From that cycle on, `unit_cfg` word k (bits 32k+31..32k) equals the working value of word k as it stood before the launching write.
- R5: `unit_running` rises in the same cycle as `unit_run`. It stays high until the cycle after `unit_done` is sampled high in a cycle other than the launch cycle, and then it falls.
- R6: A start write made while `unit_running` is high is ignored. No `unit_run` pulse follows, and `unit_cfg` keeps its value.
- R7: A read of the status word (address 1) returns bit 0 = completion flag and bit 1 = busy, with all other bits 0. The completion flag is set when a run ends and cleared when a run is launched.
- R8: A read of state word j (address 2+NUM_CFG+j) returns bits 32j+31..32j of `unit_state` as they stood in the access cycle.
- R9: A read is an access with `bus_valid` high and `bus_wstrb` equal to 0. It gives `bus_rvalid` high, with `bus_rdata`, exactly one cycle later. A write gives no `bus_rvalid`.
- R10: Reads of the control word or of an unmapped address (2+NUM_CFG+NUM_STATE and above) return 0. Writes to unmapped addresses change no configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte write strobes; all zero means read |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| unit_run | output | 1 | One-cycle launch pulse to the units |
| unit_running | output | 1 | Busy level for the duration of a run |
| unit_done | input | 1 | Completion indication from the units |
| unit_cfg | output | 32*NUM_CFG | Shadow configuration words, word k in bits 32k+31..32k |
| unit_state | input | 32*NUM_STATE | Unit status words, readable by software |

## Verification
The bench builds the block with its defaults: four configuration words, two state words and a 4-bit address. That covers the control and status words, every configuration and state slot, and eight unmapped addresses, all in a small map. With this small set of words, random writes with random strobe patterns land on each slot many times across several runs. This brings within reach the byte-merge results, writes landing in the launch cycle itself, and start requests made while busy.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned STRB_W = WORD_W / 8;

    // word map: control, status, then configuration words, then state words
    localparam int unsigned CTRL_ADDR   = 0;
    localparam int unsigned STATUS_ADDR = 1;
    localparam int unsigned CFG_BASE    = 2;

    localparam int unsigned GO_BIT      = 0;
    localparam int unsigned DONE_BIT    = 0;
    localparam int unsigned BUSY_BIT    = 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [STRB_W-1:0] strb_t;

    typedef enum logic [2:0] {
        RGN_CTRL,
        RGN_STATUS,
        RGN_CFG,
        RGN_STATE,
        RGN_NONE
    } region_e;

    typedef struct packed {
        logic        valid;
        logic        write;
        region_e     rgn;
        logic [15:0] index;
    } access_t;

    function automatic word_t merge_bytes(input word_t old_w, input word_t new_w, input strb_t strb);
        word_t res;
        res = old_w;
        for (int b = 0; b < int'(STRB_W); b++) begin
            if (strb[b]) res[8*b +: 8] = new_w[8*b +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
    import cfgbank_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned NUM_CFG   = 4,
    parameter int unsigned NUM_STATE = 2
) (
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  strb_t             bus_wstrb,
    output access_t           acc
);

    localparam int unsigned STATE_BASE = CFG_BASE + NUM_CFG;
    localparam int unsigned MAP_END    = STATE_BASE + NUM_STATE;

    always_comb begin
        int unsigned a;
        a         = 32'(bus_addr);
        acc.valid = bus_valid;
        acc.write = |bus_wstrb;
        acc.rgn   = RGN_NONE;
        acc.index = '0;
        if (a == CTRL_ADDR) begin
            acc.rgn = RGN_CTRL;
        end else if (a == STATUS_ADDR) begin
            acc.rgn = RGN_STATUS;
        end else if (a >= CFG_BASE && a < STATE_BASE) begin
            acc.rgn   = RGN_CFG;
            acc.index = 16'(a - CFG_BASE);
        end else if (a >= STATE_BASE && a < MAP_END) begin
            acc.rgn   = RGN_STATE;
            acc.index = 16'(a - STATE_BASE);
        end
    end

endmodule

// File: rtl/cfgbank_word.sv
module cfgbank_word
    import cfgbank_pkg::*;
#(
    parameter int unsigned SLOT = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  access_t acc,
    input  word_t   wdata,
    input  strb_t   wstrb,
    input  logic    load,
    output word_t   work_q,
    output word_t   shadow_q
);

    logic hit;
    assign hit = acc.valid && acc.write && (acc.rgn == RGN_CFG) && (acc.index == 16'(SLOT));

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q   <= '0;
            shadow_q <= '0;
        end else begin
            if (hit)  work_q   <= merge_bytes(work_q, wdata, wstrb);
            // snapshot takes the pre-edge working value, so a write in the same cycle waits
            if (load) shadow_q <= work_q;
        end
    end

endmodule

// File: rtl/cfgbank_sequencer.sv
module cfgbank_sequencer (
    input  logic clk,
    input  logic rst,
    input  logic go_req,
    input  logic unit_done,
    output logic launch,
    output logic run_q,
    output logic running_q,
    output logic done_q
);

    assign launch = go_req && !running_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            running_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            run_q <= launch;
            if (launch) begin
                running_q <= 1'b1;
                done_q    <= 1'b0;
            end else if (running_q && !run_q && unit_done) begin
                running_q <= 1'b0;
                done_q    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfgbank_readback.sv
module cfgbank_readback
    import cfgbank_pkg::*;
#(
    parameter int unsigned NUM_CFG   = 4,
    parameter int unsigned NUM_STATE = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  access_t acc,
    input  word_t   work_arr  [NUM_CFG],
    input  word_t   state_arr [NUM_STATE],
    input  logic    done_flag,
    input  logic    busy,
    output word_t   rdata,
    output logic    rvalid
);

    word_t pick;
    logic  is_read;

    assign is_read = acc.valid && !acc.write;

    always_comb begin
        pick = '0;
        unique case (acc.rgn)
            RGN_STATUS: begin
                pick[DONE_BIT] = done_flag;
                pick[BUSY_BIT] = busy;
            end
            RGN_CFG: begin
                for (int i = 0; i < int'(NUM_CFG); i++)
                    if (acc.index == 16'(i)) pick = work_arr[i];
            end
            RGN_STATE: begin
                for (int j = 0; j < int'(NUM_STATE); j++)
                    if (acc.index == 16'(j)) pick = state_arr[j];
            end
            default: pick = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= is_read;
            if (is_read) rdata <= pick;
        end
    end

endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
    import cfgbank_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned NUM_CFG   = 4,
    parameter int unsigned NUM_STATE = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_valid,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [31:0]                   bus_wdata,
    input  logic [3:0]                    bus_wstrb,
    output logic [31:0]                   bus_rdata,
    output logic                          bus_rvalid,
    output logic                          unit_run,
    output logic                          unit_running,
    input  logic                          unit_done,
    output logic [NUM_CFG*WORD_W-1:0]     unit_cfg,
    input  logic [NUM_STATE*WORD_W-1:0]   unit_state
);

    access_t acc;
    word_t   work_arr   [NUM_CFG];
    word_t   shadow_arr [NUM_CFG];
    word_t   state_arr  [NUM_STATE];
    logic    go_req;
    logic    launch;
    logic    done_flag;

    cfgbank_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_CFG  (NUM_CFG),
        .NUM_STATE(NUM_STATE)
    ) u_decode (
        .bus_valid(bus_valid),
        .bus_addr (bus_addr),
        .bus_wstrb(bus_wstrb),
        .acc      (acc)
    );

    assign go_req = acc.valid && acc.write && (acc.rgn == RGN_CTRL)
                 && bus_wstrb[GO_BIT / 8] && bus_wdata[GO_BIT];

    cfgbank_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .go_req   (go_req),
        .unit_done(unit_done),
        .launch   (launch),
        .run_q    (unit_run),
        .running_q(unit_running),
        .done_q   (done_flag)
    );

    for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
        cfgbank_word #(.SLOT(k)) u_word (
            .clk     (clk),
            .rst     (rst),
            .acc     (acc),
            .wdata   (bus_wdata),
            .wstrb   (bus_wstrb),
            .load    (launch),
            .work_q  (work_arr[k]),
            .shadow_q(shadow_arr[k])
        );
        assign unit_cfg[k*WORD_W +: WORD_W] = shadow_arr[k];
    end

    for (genvar j = 0; j < NUM_STATE; j++) begin : g_state
        assign state_arr[j] = unit_state[j*WORD_W +: WORD_W];
    end

    cfgbank_readback #(
        .NUM_CFG  (NUM_CFG),
        .NUM_STATE(NUM_STATE)
    ) u_readback (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .work_arr (work_arr),
        .state_arr(state_arr),
        .done_flag(done_flag),
        .busy     (unit_running),
        .rdata    (bus_rdata),
        .rvalid   (bus_rvalid)
    );

endmodule

// File: rtl/cfgbank_checker.sv
module cfgbank_checker #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned NUM_CFG = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bus_valid,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic                    bus_wdata_lsb,
    input logic [3:0]              bus_wstrb,
    input logic                    bus_rvalid,
    input logic                    unit_run,
    input logic                    unit_running,
    input logic                    unit_done,
    input logic [NUM_CFG*32-1:0]   unit_cfg
);

    logic start_wr;
    assign start_wr = bus_valid && (bus_addr == '0) && bus_wstrb[0] && bus_wdata_lsb;

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !unit_run |-> $stable(unit_cfg));

    assert_run_single_R4: assert property (@(posedge clk) disable iff (rst)
        unit_run |=> !unit_run);

    assert_start_launch_R4: assert property (@(posedge clk) disable iff (rst)
        (start_wr && !unit_running) |=> unit_run);

    assert_busy_with_run_R5: assert property (@(posedge clk) disable iff (rst)
        unit_run |-> unit_running);

    assert_busy_release_R5: assert property (@(posedge clk) disable iff (rst)
        (unit_running && !unit_run && unit_done) |=> !unit_running);

    assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (start_wr && unit_running) |=> !unit_run);

    assert_read_answer_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_wstrb == 4'b0) |=> bus_rvalid);

    assert_write_silent_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_wstrb != 4'b0) |=> !bus_rvalid);

endmodule

bind cfg_shadow_bank cfgbank_checker #(
    .ADDR_W (ADDR_W),
    .NUM_CFG(NUM_CFG)
) u_checker (
    .clk          (clk),
    .rst          (rst),
    .bus_valid    (bus_valid),
    .bus_addr     (bus_addr),
    .bus_wdata_lsb(bus_wdata[0]),
    .bus_wstrb    (bus_wstrb),
    .bus_rvalid   (bus_rvalid),
    .unit_run     (unit_run),
    .unit_running (unit_running),
    .unit_done    (unit_done),
    .unit_cfg     (unit_cfg)
);

// File: tb/cfg_shadow_bank_tb.sv
module cfg_shadow_bank_tb;

    localparam int NCFG = 4;
    localparam int NST  = 2;
    localparam int AW   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [3:0]        bus_wstrb = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic              unit_run;
    logic              unit_running;
    logic              unit_done = 1'b0;
    logic [NCFG*32-1:0] unit_cfg;
    logic [NST*32-1:0]  unit_state = '0;

    int checks = 0;
    int errors = 0;

    logic [31:0] work_m   [NCFG];
    logic [31:0] shadow_m [NCFG];

    always #5 clk = ~clk;

    cfg_shadow_bank #(.ADDR_W(AW), .NUM_CFG(NCFG), .NUM_STATE(NST)) u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .unit_run(unit_run), .unit_running(unit_running),
        .unit_done(unit_done), .unit_cfg(unit_cfg), .unit_state(unit_state)
    );

    function automatic logic [31:0] merge_ref(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = s[b] ? n[8*b +: 8] : o[8*b +: 8];
        return r;
    endfunction

    function automatic logic [NCFG*32-1:0] shadow_flat();
        logic [NCFG*32-1:0] f;
        for (int k = 0; k < NCFG; k++) f[k*32 +: 32] = shadow_m[k];
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one access, ends at the falling edge after the capturing rising edge
    task automatic bus_write(input int a, input logic [31:0] d, input logic [3:0] s);
        bus_valid = 1'b1; bus_addr = AW'(a); bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        bus_valid = 1'b0; bus_wstrb = '0;
        if (a >= 2 && a < 2 + NCFG) work_m[a-2] = merge_ref(work_m[a-2], d, s);
        check(bus_rvalid == 1'b0, "R9 write gives no rvalid", 128'(bus_rvalid), 0);
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        bus_valid = 1'b1; bus_addr = AW'(a); bus_wstrb = '0;
        @(negedge clk);
        bus_valid = 1'b0;
        check(bus_rvalid == 1'b1, "R9 read rvalid next cycle", 128'(bus_rvalid), 1);
        d = bus_rdata;
    endtask

    task automatic check_cfg_words(input string req);
        logic [31:0] d;
        for (int k = 0; k < NCFG; k++) begin
            bus_read(2 + k, d);
            check(d == work_m[k], req, 128'(d), 128'(work_m[k]));
        end
    endtask

    task automatic start_run();
        logic [NCFG*32-1:0] snap;
        for (int k = 0; k < NCFG; k++) shadow_m[k] = work_m[k];
        snap = shadow_flat();
        bus_write(0, 32'h1, 4'h1);
        check(unit_run == 1'b1, "R4 run pulse after start", 128'(unit_run), 1);
        check(unit_cfg == snap, "R4 shadow loaded at launch", 128'(unit_cfg), 128'(snap));
        check(unit_running == 1'b1, "R5 busy with run pulse", 128'(unit_running), 1);
    endtask

    task automatic end_run();
        logic [31:0] d;
        unit_done = 1'b1;
        @(negedge clk);
        unit_done = 1'b0;
        check(unit_running == 1'b0, "R5 busy drops after done", 128'(unit_running), 0);
        bus_read(1, d);
        check(d == 32'h1, "R7 status after completion", 128'(d), 1);
    endtask

    task automatic random_cfg_write(input string req);
        int a;
        logic [31:0] d;
        logic [3:0] s;
        a = 2 + int'($urandom % NCFG);
        d = $urandom;
        s = 4'($urandom % 15 + 1);
        bus_write(a, d, s);
        check(unit_cfg == shadow_flat(), req, 128'(unit_cfg), 128'(shadow_flat()));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'h5eed_1234));
        for (int k = 0; k < NCFG; k++) begin work_m[k] = '0; shadow_m[k] = '0; end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(unit_run == 0 && unit_running == 0 && bus_rvalid == 0, "R1 control outputs after reset",
              128'({unit_run, unit_running, bus_rvalid}), 0);
        check(unit_cfg == '0, "R1 shadow cleared", 128'(unit_cfg), 0);
        bus_read(1, d);
        check(d == 32'h0, "R1 status after reset", 128'(d), 0);

        // directed byte merge
        bus_write(2, 32'hAABBCCDD, 4'hF);
        bus_write(2, 32'h11223344, 4'b0101);
        bus_read(2, d);
        check(d == 32'hAA22CC44, "R2 strobe merge", 128'(d), 128'(32'hAA22CC44));
        check(unit_cfg == '0, "R3 idle write not visible", 128'(unit_cfg), 0);

        // unmapped and control reads/writes
        bus_write(12, 32'hFFFFFFFF, 4'hF);
        bus_read(12, d);
        check(d == 0, "R10 unmapped reads zero", 128'(d), 0);
        bus_read(0, d);
        check(d == 0, "R10 control reads zero", 128'(d), 0);
        check_cfg_words("R10 unmapped write leaves config");

        for (int run = 0; run < 6; run++) begin
            for (int i = 0; i < 4; i++) random_cfg_write("R3 idle write not visible");
            check_cfg_words("R2 working readback");
            start_run();
            // write landing in the launch cycle
            random_cfg_write("R3 write in launch cycle not visible");
            check(unit_run == 1'b0, "R4 run pulse one cycle", 128'(unit_run), 0);
            bus_read(1, d);
            check(d == 32'h2, "R7 status while busy", 128'(d), 2);
            for (int i = 0; i < 5; i++) random_cfg_write("R3 write during run not visible");
            // start while busy
            bus_write(0, 32'h1, 4'h1);
            check(unit_run == 1'b0, "R6 start while busy ignored", 128'(unit_run), 0);
            check(unit_cfg == shadow_flat(), "R6 shadow kept on busy start", 128'(unit_cfg), 128'(shadow_flat()));
            // state readback
            unit_state = {32'($urandom), 32'($urandom)};
            for (int j = 0; j < NST; j++) begin
                bus_read(2 + NCFG + j, d);
                check(d == unit_state[j*32 +: 32], "R8 state readback", 128'(d), 128'(unit_state[j*32 +: 32]));
            end
            check(unit_running == 1'b1, "R5 busy held until done", 128'(unit_running), 1);
            end_run();
            check(unit_cfg == shadow_flat(), "R3 config held after run", 128'(unit_cfg), 128'(shadow_flat()));
        end

        // start write with bit 0 clear does nothing
        bus_write(0, 32'h2, 4'hF);
        check(unit_run == 1'b0 && unit_running == 1'b0, "R4 no launch without go bit",
              128'({unit_run, unit_running}), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule